// File: doc/BRIEF.md
# In-Order Retire Control Buffer

This block tracks in-flight instructions between dispatch and retirement in an out-of-order core. It holds a ring of slots. An instruction that is being dispatched asks for one or more slots. If enough slots are free, the request is granted and the instruction receives a token, which is the ring position of its first slot. The instruction's metadata (its index, the number of slots it holds and a completion flag) is stored at that position.

When the instruction finishes executing, the execution side presents the token and the entry is marked complete. On every clock edge the block retires entries in program order, starting at the oldest one. It stops at the first entry that has not completed, or when the per-cycle retire limit is reached. A limit of 0 means no limit. Each retired entry returns its slots to the free pool and is reported on a retire lane with its instruction index.

Slot requests are clamped: a request of zero counts as one slot, and a request larger than the ring counts as the whole ring. A request that cannot be granted changes nothing, and an overflow pulse follows on the next cycle.

Top module: `retire_ctrl_buf`

## Requirements
- R1: After reset the free count equals DEPTH, `empty` is 1, `full` is 0, no retire lane is valid and `ovf_err` is 0.
- R2: `rsv_token` always shows the next free position. Each granted request moves it forward by the request's effective slot count, modulo DEPTH.
- R3: The effective slot count is 1 for a request of 0, DEPTH for a request of DEPTH or more, and the requested value otherwise.
- R4: `rsv_ok` is 1 only when `rsv_valid` is 1 and the free count is at least the effective count. A refused request leaves the free count and the token unchanged, and `ovf_err` is 1 for exactly the cycle after it.
- R5: An `exec_valid` pulse with a token marks that entry complete. A completed entry does not retire while any older entry is still incomplete.
- R6: Retire lanes are filled oldest first, starting at lane 0 and with no gaps. Each valid lane carries its entry's instruction index. The entry retires at the clock edge where its lane is shown valid.
- R7: At most RETIRE_MAX entries retire per cycle, and RETIRE_MAX = 0 allows up to DEPTH entries per cycle.
- R8: The slots of retired entries are added to the free count at the edge of retirement. `full` means zero free slots and `empty` means DEPTH free slots.
- R9: An entry that fills the whole ring retires exactly once, even though the position after it is the same slot again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Slot reservation request |
| rsv_idx | input | IDX_W | Instruction index of the request |
| rsv_cnt | input | REQ_W | Requested slot count |
| rsv_ok | output | 1 | Request granted this cycle |
| rsv_token | output | PTR_W | Token (first slot) given to the request |
| exec_valid | input | 1 | Completion notification |
| exec_token | input | PTR_W | Token of the completed entry |
| ret_valid | output | LANES | Retire lane valid, lane 0 oldest |
| ret_idx | output | LANES x IDX_W | Instruction index per retire lane |
| free_cnt | output | CNT_W | Free slots |
| full | output | 1 | No free slot |
| empty | output | 1 | All slots free |
| ovf_err | output | 1 | Pulse after a refused request |

## Verification
`rsv_ok` and `rsv_token` depend only on the inputs and the current state, so the bench drives a request after the falling edge and checks them 1 ns later, within the same cycle. `free_cnt`, `full`, `empty` and `ovf_err` are registered, so their checks come one rising edge after the stimulus, at the following falling edge. A completion notification reaches the retire lanes one edge after it is applied. The retirement it allows takes effect on the edge after that, so each lane check is followed by one more edge before the free count is checked.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

   // Number of retire lanes built for a given limit (0 = unlimited).
   function automatic int lane_count(input int max_r, input int depth);
      return (max_r == 0 || max_r > depth) ? depth : max_r;
   endfunction

endpackage

// File: rtl/rcb_alloc.sv
module rcb_alloc #(
   parameter int DEPTH = 8,
   parameter int REQ_W = 8,
   parameter int PTR_W = 3,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rsv_valid,
   input  logic [REQ_W-1:0] rsv_cnt,
   input  logic [CNT_W-1:0] ret_slots,
   output logic             rsv_ok,
   output logic [CNT_W-1:0] eff_cnt,
   output logic [PTR_W-1:0] tail,
   output logic [CNT_W-1:0] free_cnt,
   output logic             ovf_err
);

   logic [PTR_W-1:0] tail_q;
   logic [CNT_W-1:0] free_q;
   logic             ovf_q;

   always_comb begin
      if (rsv_cnt == '0)
         eff_cnt = CNT_W'(1);
      else if (rsv_cnt >= REQ_W'(DEPTH))
         eff_cnt = CNT_W'(DEPTH);
      else
         eff_cnt = CNT_W'(rsv_cnt);
   end

   assign rsv_ok   = rsv_valid && (free_q >= eff_cnt);
   assign tail     = tail_q;
   assign free_cnt = free_q;
   assign ovf_err  = ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tail_q <= '0;
         free_q <= CNT_W'(DEPTH);
         ovf_q  <= 1'b0;
      end else begin
         free_q <= free_q - (rsv_ok ? eff_cnt : '0) + ret_slots;
         if (rsv_ok)
            tail_q <= tail_q + PTR_W'(eff_cnt);
         ovf_q <= rsv_valid && !rsv_ok;
      end
   end

   AST_OVF_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_valid && !rsv_ok |=> ovf_err); // R4
   AST_FREE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      free_q <= CNT_W'(DEPTH)); // R8

endmodule

// File: rtl/rcb_store.sv
module rcb_store #(
   parameter int DEPTH = 8,
   parameter int IDX_W = 8,
   parameter int PTR_W = 3,
   parameter int CNT_W = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [PTR_W-1:0]                wr_ptr,
   input  logic [IDX_W-1:0]                wr_idx,
   input  logic [CNT_W-1:0]                wr_nsl,
   input  logic                            ex_en,
   input  logic [PTR_W-1:0]                ex_ptr,
   input  logic [DEPTH-1:0]                clr_mask,
   output logic [DEPTH-1:0]                vld,
   output logic [DEPTH-1:0]                exe,
   output logic [DEPTH-1:0][IDX_W-1:0]     idx,
   output logic [DEPTH-1:0][CNT_W-1:0]     nsl
);

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[s] <= 1'b0;
            exe[s] <= 1'b0;
            idx[s] <= '0;
            nsl[s] <= '0;
         end else if (wr_en && wr_ptr == PTR_W'(s)) begin
            vld[s] <= 1'b1;
            exe[s] <= 1'b0;
            idx[s] <= wr_idx;
            nsl[s] <= wr_nsl;
         end else if (clr_mask[s]) begin
            vld[s] <= 1'b0;
            exe[s] <= 1'b0;
         end else if (ex_en && ex_ptr == PTR_W'(s) && vld[s]) begin
            exe[s] <= 1'b1;
         end
      end
   end

   AST_WRITE_TO_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !vld[wr_ptr]); // R4
   AST_EXEC_TO_LIVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ex_en |-> vld[ex_ptr]); // R5

endmodule

// File: rtl/rcb_retire.sv
module rcb_retire #(
   parameter int DEPTH = 8,
   parameter int IDX_W = 8,
   parameter int LANES = 2,
   parameter int PTR_W = 3,
   parameter int CNT_W = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [CNT_W-1:0]                used,
   input  logic [DEPTH-1:0]                vld,
   input  logic [DEPTH-1:0]                exe,
   input  logic [DEPTH-1:0][IDX_W-1:0]     idx,
   input  logic [DEPTH-1:0][CNT_W-1:0]     nsl,
   output logic [LANES-1:0]                ret_valid,
   output logic [LANES-1:0][IDX_W-1:0]     ret_idx,
   output logic [DEPTH-1:0]                clr_mask,
   output logic [CNT_W-1:0]                ret_slots
);

   localparam int SW = CNT_W + 1;

   logic [PTR_W-1:0] head_q;
   logic [PTR_W-1:0] pos [LANES+1];
   logic [SW-1:0]    cum [LANES+1];
   logic             go  [LANES+1];

   assign pos[0] = head_q;
   assign cum[0] = '0;
   assign go[0]  = 1'b1;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign ret_valid[k] = go[k] && (cum[k] < SW'(used)) && vld[pos[k]] && exe[pos[k]];
      assign ret_idx[k]   = idx[pos[k]];
      assign pos[k+1]     = pos[k] + PTR_W'(nsl[pos[k]]);
      assign cum[k+1]     = ret_valid[k] ? cum[k] + SW'(nsl[pos[k]]) : cum[k];
      assign go[k+1]      = ret_valid[k];
   end

   assign ret_slots = CNT_W'(cum[LANES]);

   always_comb begin
      clr_mask = '0;
      for (int k = 0; k < LANES; k++)
         if (ret_valid[k])
            clr_mask[pos[k]] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         head_q <= '0;
      else
         head_q <= head_q + PTR_W'(ret_slots);
   end

   AST_RETIRE_WITHIN_USED: assert property (@(posedge clk) disable iff (!rst_n)
      ret_slots <= used); // R9

endmodule

// File: rtl/retire_ctrl_buf.sv
module retire_ctrl_buf #(
   parameter int DEPTH      = 8,
   parameter int IDX_W      = 8,
   parameter int REQ_W      = 8,
   parameter int RETIRE_MAX = 2,
   localparam int PTR_W     = $clog2(DEPTH),
   localparam int CNT_W     = PTR_W + 1,
   localparam int LANES     = rcb_pkg::lane_count(RETIRE_MAX, DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rsv_valid,
   input  logic [IDX_W-1:0]            rsv_idx,
   input  logic [REQ_W-1:0]            rsv_cnt,
   output logic                        rsv_ok,
   output logic [PTR_W-1:0]            rsv_token,
   input  logic                        exec_valid,
   input  logic [PTR_W-1:0]            exec_token,
   output logic [LANES-1:0]            ret_valid,
   output logic [LANES-1:0][IDX_W-1:0] ret_idx,
   output logic [CNT_W-1:0]            free_cnt,
   output logic                        full,
   output logic                        empty,
   output logic                        ovf_err
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("retire_ctrl_buf: DEPTH must be a power of two of at least 2");
   end
   if (REQ_W < CNT_W) begin : g_bad_req
      $error("retire_ctrl_buf: REQ_W must be able to hold DEPTH");
   end
   if (RETIRE_MAX < 0) begin : g_bad_lim
      $error("retire_ctrl_buf: RETIRE_MAX must not be negative");
   end

   logic [CNT_W-1:0]                eff_cnt;
   logic [CNT_W-1:0]                ret_slots;
   logic [CNT_W-1:0]                used;
   logic [DEPTH-1:0]                vld;
   logic [DEPTH-1:0]                exe;
   logic [DEPTH-1:0][IDX_W-1:0]     idx;
   logic [DEPTH-1:0][CNT_W-1:0]     nsl;
   logic [DEPTH-1:0]                clr_mask;

   rcb_alloc #(
      .DEPTH(DEPTH), .REQ_W(REQ_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
   ) u_alloc (
      .clk(clk), .rst_n(rst_n),
      .rsv_valid(rsv_valid), .rsv_cnt(rsv_cnt), .ret_slots(ret_slots),
      .rsv_ok(rsv_ok), .eff_cnt(eff_cnt), .tail(rsv_token),
      .free_cnt(free_cnt), .ovf_err(ovf_err)
   );

   rcb_store #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rsv_ok), .wr_ptr(rsv_token), .wr_idx(rsv_idx), .wr_nsl(eff_cnt),
      .ex_en(exec_valid), .ex_ptr(exec_token), .clr_mask(clr_mask),
      .vld(vld), .exe(exe), .idx(idx), .nsl(nsl)
   );

   assign used = CNT_W'(DEPTH) - free_cnt;

   rcb_retire #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .LANES(LANES), .PTR_W(PTR_W), .CNT_W(CNT_W)
   ) u_retire (
      .clk(clk), .rst_n(rst_n), .used(used),
      .vld(vld), .exe(exe), .idx(idx), .nsl(nsl),
      .ret_valid(ret_valid), .ret_idx(ret_idx),
      .clr_mask(clr_mask), .ret_slots(ret_slots)
   );

   assign full  = (free_cnt == '0);
   assign empty = (free_cnt == CNT_W'(DEPTH));

   AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !rsv_ok); // R8
   AST_EMPTY_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> ret_valid == '0); // R6
   AST_FREE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rsv_ok && ret_valid == '0 |=> $stable(free_cnt)); // R8

endmodule

// File: tb/retire_ctrl_buf_bench.sv
module retire_ctrl_buf_bench;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // limited instance (RETIRE_MAX = 2)
   logic            rsv_valid = 0, exec_valid = 0;
   logic [7:0]      rsv_idx = 0, rsv_cnt = 0;
   logic [2:0]      exec_token = 0;
   logic            rsv_ok, full, empty, ovf_err;
   logic [2:0]      rsv_token;
   logic [1:0]      ret_valid;
   logic [1:0][7:0] ret_idx;
   logic [3:0]      free_cnt;

   retire_ctrl_buf #(.DEPTH(8), .IDX_W(8), .REQ_W(8), .RETIRE_MAX(2)) u_retire_ctrl_buf (
      .clk(clk), .rst_n(rst_n),
      .rsv_valid(rsv_valid), .rsv_idx(rsv_idx), .rsv_cnt(rsv_cnt),
      .rsv_ok(rsv_ok), .rsv_token(rsv_token),
      .exec_valid(exec_valid), .exec_token(exec_token),
      .ret_valid(ret_valid), .ret_idx(ret_idx),
      .free_cnt(free_cnt), .full(full), .empty(empty), .ovf_err(ovf_err)
   );

   // unlimited instance (RETIRE_MAX = 0)
   logic            u_rv = 0, u_ev = 0;
   logic [7:0]      u_ri = 0, u_rc = 0;
   logic [2:0]      u_et = 0;
   logic            u_ok, u_full, u_empty, u_ovf;
   logic [2:0]      u_tok;
   logic [7:0]      u_retv;
   logic [7:0][7:0] u_reti;
   logic [3:0]      u_free;

   retire_ctrl_buf #(.DEPTH(8), .IDX_W(8), .REQ_W(8), .RETIRE_MAX(0)) u_unl (
      .clk(clk), .rst_n(rst_n),
      .rsv_valid(u_rv), .rsv_idx(u_ri), .rsv_cnt(u_rc),
      .rsv_ok(u_ok), .rsv_token(u_tok),
      .exec_valid(u_ev), .exec_token(u_et),
      .ret_valid(u_retv), .ret_idx(u_reti),
      .free_cnt(u_free), .full(u_full), .empty(u_empty), .ovf_err(u_ovf)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // {idx[33:26], cnt[25:18], ok[17], token[16:9], free_after[8:1], ovf_after[0]}
   localparam logic [33:0] VEC [5] = '{
      {8'd10, 8'd1, 1'b1, 8'd0, 8'd7, 1'b0},
      {8'd11, 8'd3, 1'b1, 8'd1, 8'd4, 1'b0},
      {8'd12, 8'd2, 1'b1, 8'd4, 8'd2, 1'b0},
      {8'd13, 8'd0, 1'b1, 8'd6, 8'd1, 1'b0},
      {8'd14, 8'd2, 1'b0, 8'd7, 8'd1, 1'b1}
   };

   task automatic ex_top(input logic [2:0] tok);
      exec_valid = 1; exec_token = tok;
      tick;
      exec_valid = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 free", free_cnt, 8);
      chk("R1 empty", empty, 1);
      chk("R1 full", full, 0);
      chk("R1 ret_valid", ret_valid, 0);
      chk("R1 ovf", ovf_err, 0);
      @(negedge clk);

      // table walk: R2 tokens, R3 zero count, R4 refusal
      foreach (VEC[i]) begin
         rsv_valid = 1; rsv_idx = VEC[i][33:26]; rsv_cnt = VEC[i][25:18];
         #1;
         chk("R4 rsv_ok", rsv_ok, VEC[i][17]);
         chk("R2 token", rsv_token, VEC[i][16:9]);
         tick;
         rsv_valid = 0;
         chk("R3 free after reserve", free_cnt, VEC[i][8:1]);
         chk("R4 ovf pulse", ovf_err, VEC[i][0]);
      end
      tick;
      chk("R4 ovf one cycle", ovf_err, 0);

      // R5: out-of-order completion waits for the head
      ex_top(3'd1);
      chk("R5 no retire past head", ret_valid, 0);
      ex_top(3'd4);
      chk("R5 still blocked", ret_valid, 0);
      ex_top(3'd0);
      chk("R7 two lanes at limit", ret_valid, 2'b11);
      chk("R6 lane0 idx", ret_idx[0], 10);
      chk("R6 lane1 idx", ret_idx[1], 11);
      chk("R8 free before edge", free_cnt, 1);
      tick;
      chk("R8 free after retire", free_cnt, 5);
      chk("R6 stops at incomplete", ret_valid, 2'b01);
      chk("R6 lane0 idx next", ret_idx[0], 12);
      tick;
      chk("R8 free after second retire", free_cnt, 7);
      chk("R6 nothing ready", ret_valid, 0);

      // R3: oversize request capped to DEPTH, refused with 7 free
      rsv_valid = 1; rsv_idx = 15; rsv_cnt = 20;
      #1;
      chk("R3 capped request refused", rsv_ok, 0);
      tick;
      rsv_valid = 0;
      chk("R4 ovf on capped refusal", ovf_err, 1);
      chk("R4 free unchanged", free_cnt, 7);
      ex_top(3'd6);
      chk("R6 last entry", ret_valid, 2'b01);
      chk("R6 last idx", ret_idx[0], 13);
      tick;
      chk("R8 empty again", empty, 1);

      // R3/R9: whole-ring entry
      rsv_valid = 1; rsv_idx = 16; rsv_cnt = 20;
      #1;
      chk("R3 capped request granted", rsv_ok, 1);
      chk("R2 token for ring entry", rsv_token, 7);
      tick;
      chk("R8 full", full, 1);
      rsv_idx = 99; rsv_cnt = 1;
      #1;
      chk("R8 full refuses", rsv_ok, 0);
      rsv_valid = 0;
      ex_top(3'd7);
      chk("R9 ring entry once", ret_valid, 2'b01);
      chk("R9 ring idx", ret_idx[0], 16);
      tick;
      chk("R9 free restored", free_cnt, 8);

      // R2: wrap of the token
      rsv_valid = 1; rsv_idx = 17; rsv_cnt = 2;
      #1;
      chk("R2 token before wrap", rsv_token, 7);
      tick;
      rsv_idx = 18; rsv_cnt = 1;
      #1;
      chk("R2 token after wrap", rsv_token, 1);
      tick;
      rsv_valid = 0;

      // R7: unlimited instance retires all ready entries in one cycle
      for (int j = 0; j < 3; j++) begin
         u_rv = 1; u_ri = 8'(30 + j); u_rc = 1;
         #1;
         chk("R2 unlimited token", u_tok, j);
         tick;
      end
      u_rv = 0;
      for (int j = 2; j >= 0; j--) begin
         u_ev = 1; u_et = 3'(j);
         tick;
         u_ev = 0;
         if (j > 0) chk("R5 unlimited blocked", u_retv, 0);
      end
      chk("R7 unlimited lanes", u_retv, 8'h07);
      chk("R6 unlimited lane0", u_reti[0], 30);
      chk("R6 unlimited lane1", u_reti[1], 31);
      chk("R6 unlimited lane2", u_reti[2], 32);
      tick;
      chk("R8 unlimited empty", u_empty, 1);

      done = 1;
      summary;
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary;
         $finish;
      end
   end

endmodule